// File: doc/BRIEF.md
# DRAM Rank Refresh Sequencer

This block keeps one DRAM rank refreshed. A free-running interval timer requests a refresh at a fixed period. The block then runs a short sequence. It waits until the rank has no accesses in flight. It wakes the rank if the rank is in power-down. It closes any open banks with a precharge-all, issues the refresh command and waits out the refresh recovery time before it hands the rank back to the scheduler.

The sequence has one more branch. When the rank must go back into self-refresh after a refresh, the sequencer parks in a self-refresh-exit state. It leaves that state only when the power logic reports that the exit is complete, and it then runs a fresh sequence. Read and write bursts to the rank are allowed only while the sequencer is idle.

Command arbitration, the power state machine itself and any energy accounting sit outside this block. They reach it only through the ports below.

Top module: `refresh_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `seq_state` is 0 (idle), `burst_ok` is 1 and `pre_all_stb`, `ref_stb` and `wake_req` are 0. State codes: 0 idle, 1 self-refresh exit, 2 drain, 3 power-down exit, 4 precharge, 5 refresh start, 6 refresh run.
- R2: `burst_ok` is 1 exactly in the cycles where `seq_state` is idle (0).
- R3: The interval timer counts REFI_CYCLES. Drain (2) is entered REFI_CYCLES cycles after the first cycle following reset. After that, it is entered REFI_CYCLES cycles after each cycle in which `ref_stb` is high, provided the sequencer is idle by then. If the interval ran out while the sequencer was busy, drain follows the first idle cycle.
- R4: Drain stays in state 2 while `pending_cnt` is nonzero. It moves to power-down exit (3) on the clock edge at which `pending_cnt` is 0.
- R5: In power-down exit (3), `wake_req` equals `rank_asleep`, and the state holds while `rank_asleep` is 1.
- R6: When power-down exit (3) sees `rank_asleep` at 0, it moves to precharge (4) if `bank_open` is 1, and otherwise to refresh start (5).
- R7: `pre_all_stb` is high only in the first cycle of precharge (4). Refresh start (5) follows RP_CYCLES cycles after that cycle.
- R8: `ref_stb` is high for exactly one cycle, the single cycle of refresh start (5). Refresh run (6) then lasts RFC_CYCLES cycles.
- R9: In the last cycle of refresh run, `sref_reenter` at 1 selects self-refresh exit (1) as the next state, and at 0 selects idle (0).
- R10: Self-refresh exit (1) holds until `sref_exit_done` is 1, then moves to drain (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pending_cnt | input | PEND_W | Number of accesses still in flight to the rank |
| rank_asleep | input | 1 | Rank is in a power-down state |
| bank_open | input | 1 | At least one bank of the rank holds an open row |
| sref_reenter | input | 1 | Rank returns to self-refresh once this refresh is done |
| sref_exit_done | input | 1 | Self-refresh exit has completed |
| burst_ok | output | 1 | Scheduler may issue read and write bursts to the rank |
| pre_all_stb | output | 1 | One-cycle precharge-all command strobe |
| ref_stb | output | 1 | One-cycle refresh command strobe |
| wake_req | output | 1 | Request to the power logic to wake the rank |
| seq_state | output | 3 | Current sequencer state code (see R1) |

## Verification
A corrupted state register shows up at once on `seq_state` and `burst_ok`, in the same cycle. A timer that is off by one count shows up later. It moves a `ref_stb` or `pre_all_stb` edge, or the next entry into drain, by one cycle, and that appears only when the timed phase ends. That is at most RFC_CYCLES cycles later for the refresh-run timer and REFI_CYCLES cycles later for the interval timer. The bench therefore compares every output on every clock against a model that keeps time with absolute cycle stamps. A drift of a single cycle is reported in the first cycle where it appears.

// File: rtl/refseq_pkg.sv
`timescale 1ns/1ps
package refseq_pkg;

    // Sequencer state codes; values are visible on seq_state.
    typedef enum logic [2:0] {
        RS_IDLE      = 3'd0,
        RS_SREF_EXIT = 3'd1,
        RS_DRAIN     = 3'd2,
        RS_PD_EXIT   = 3'd3,
        RS_PRE       = 3'd4,
        RS_START     = 3'd5,
        RS_RUN       = 3'd6
    } rs_state_e;

    typedef struct packed {
        rs_state_e st;
        logic      pre_stb;
        logic      ref_stb;
    } rs_regs_t;

endpackage

// File: rtl/refseq_interval.sv
`timescale 1ns/1ps
// Refresh interval down-counter: reloads on request, saturates at zero.
module refseq_interval #(
    parameter int PERIOD = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic due
);
    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LOAD = W'(PERIOD - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } iv_regs_t;

    iv_regs_t iv_q, iv_d;

    always_comb begin
        iv_d = iv_q;
        if (reload) begin
            iv_d.cnt = LOAD;
        end else if (iv_q.cnt != '0) begin
            iv_d.cnt = iv_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv_q <= '{cnt: LOAD};
        end else begin
            iv_q <= iv_d;
        end
    end

    assign due = (iv_q.cnt == '0);
endmodule

// File: rtl/refseq_phase.sv
`timescale 1ns/1ps
// Phase timer for the precharge and refresh-recovery waits.
module refseq_phase #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             done
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } ph_regs_t;

    ph_regs_t ph_q, ph_d;

    always_comb begin
        ph_d = ph_q;
        if (load) begin
            ph_d.cnt = load_val;
        end else if (ph_q.cnt != '0) begin
            ph_d.cnt = ph_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '{cnt: '0};
        end else begin
            ph_q <= ph_d;
        end
    end

    assign done = (ph_q.cnt == '0);
endmodule

// File: rtl/refresh_sequencer.sv
`timescale 1ns/1ps
module refresh_sequencer
    import refseq_pkg::*;
#(
    parameter int REFI_CYCLES = 3900,
    parameter int RFC_CYCLES  = 260,
    parameter int RP_CYCLES   = 14,
    parameter int PEND_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] pending_cnt,
    input  logic              rank_asleep,
    input  logic              bank_open,
    input  logic              sref_reenter,
    input  logic              sref_exit_done,
    output logic              burst_ok,
    output logic              pre_all_stb,
    output logic              ref_stb,
    output logic              wake_req,
    output logic [2:0]        seq_state
);
    localparam int PH_MAX = (RFC_CYCLES > RP_CYCLES) ? RFC_CYCLES : RP_CYCLES;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam logic [PH_W-1:0] RP_LOAD  = PH_W'(RP_CYCLES - 1);
    localparam logic [PH_W-1:0] RFC_LOAD = PH_W'(RFC_CYCLES - 1);

    rs_regs_t        seq_q, seq_d;
    logic            refi_due;
    logic            phase_done;
    logic            phase_load;
    logic [PH_W-1:0] phase_val;

    refseq_interval #(.PERIOD(REFI_CYCLES)) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (seq_d.ref_stb),
        .due    (refi_due)
    );

    refseq_phase #(.WIDTH(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .done     (phase_done)
    );

    always_comb begin
        seq_d         = seq_q;
        seq_d.pre_stb = 1'b0;
        seq_d.ref_stb = 1'b0;
        phase_load    = 1'b0;
        phase_val     = RFC_LOAD;
        case (seq_q.st)
            RS_IDLE: begin
                if (refi_due) seq_d.st = RS_DRAIN;
            end
            RS_DRAIN: begin
                if (pending_cnt == '0) seq_d.st = RS_PD_EXIT;
            end
            RS_PD_EXIT: begin
                if (!rank_asleep) begin
                    if (bank_open) begin
                        seq_d.st      = RS_PRE;
                        seq_d.pre_stb = 1'b1;
                        phase_load    = 1'b1;
                        phase_val     = RP_LOAD;
                    end else begin
                        seq_d.st      = RS_START;
                        seq_d.ref_stb = 1'b1;
                    end
                end
            end
            RS_PRE: begin
                if (phase_done) begin
                    seq_d.st      = RS_START;
                    seq_d.ref_stb = 1'b1;
                end
            end
            RS_START: begin
                seq_d.st   = RS_RUN;
                phase_load = 1'b1;
                phase_val  = RFC_LOAD;
            end
            RS_RUN: begin
                if (phase_done) seq_d.st = sref_reenter ? RS_SREF_EXIT : RS_IDLE;
            end
            RS_SREF_EXIT: begin
                if (sref_exit_done) seq_d.st = RS_DRAIN;
            end
            default: seq_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: RS_IDLE, pre_stb: 1'b0, ref_stb: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign burst_ok    = (seq_q.st == RS_IDLE);
    assign wake_req    = (seq_q.st == RS_PD_EXIT) && rank_asleep;
    assign pre_all_stb = seq_q.pre_stb;
    assign ref_stb     = seq_q.ref_stb;
    assign seq_state   = seq_q.st;
endmodule

// File: rtl/refresh_sequencer_chk.sv
`timescale 1ns/1ps
module refresh_sequencer_chk
    import refseq_pkg::*;
#(
    parameter int PEND_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PEND_W-1:0] pending_cnt,
    input logic              rank_asleep,
    input logic              bank_open,
    input logic              sref_reenter,
    input logic              sref_exit_done,
    input logic              burst_ok,
    input logic              pre_all_stb,
    input logic              ref_stb,
    input logic              wake_req,
    input logic [2:0]        seq_state
);
    p_no_burst_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != 3'd0) |-> !burst_ok);

    p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd2 && pending_cnt != '0) |=> (seq_state == 3'd2));

    p_drain_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd2 && pending_cnt == '0) |=> (seq_state == 3'd3));

    p_wake_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd3 && rank_asleep) |-> wake_req ##1 (seq_state == 3'd3));

    p_pd_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd3 && !rank_asleep && bank_open) |=> (seq_state == 3'd4));

    p_pre_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_stb |-> (seq_state == 3'd4) && ($past(seq_state) != 3'd4));

    p_ref_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |=> !ref_stb && (seq_state == 3'd6));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_all_stb && ref_stb));

    p_sref_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd1 && !sref_exit_done) |=> (seq_state == 3'd1));
endmodule

bind refresh_sequencer refresh_sequencer_chk #(.PEND_W(PEND_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pending_cnt    (pending_cnt),
    .rank_asleep    (rank_asleep),
    .bank_open      (bank_open),
    .sref_reenter   (sref_reenter),
    .sref_exit_done (sref_exit_done),
    .burst_ok       (burst_ok),
    .pre_all_stb    (pre_all_stb),
    .ref_stb        (ref_stb),
    .wake_req       (wake_req),
    .seq_state      (seq_state)
);

// File: tb/refresh_sequencer_test.sv
`timescale 1ns/1ps
module refresh_sequencer_test;
    localparam int REFI = 40;
    localparam int RFC  = 6;
    localparam int RP   = 3;
    localparam int PW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pend = '0;
    logic          asleep = 1'b0;
    logic          open_b = 1'b0;
    logic          sref = 1'b0;
    logic          sdone = 1'b0;
    logic          burst_ok, pre_all_stb, ref_stb, wake_req;
    logic [2:0]    seq_state;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    refresh_sequencer #(
        .REFI_CYCLES(REFI), .RFC_CYCLES(RFC), .RP_CYCLES(RP), .PEND_W(PW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pending_cnt(pend), .rank_asleep(asleep),
        .bank_open(open_b), .sref_reenter(sref), .sref_exit_done(sdone),
        .burst_ok(burst_ok), .pre_all_stb(pre_all_stb), .ref_stb(ref_stb),
        .wake_req(wake_req), .seq_state(seq_state)
    );

    // Reference model: absolute cycle stamps instead of counters.
    int ms = 0;
    int cyc = 0;
    int ref_at = 0;
    int pre_at = 0;
    int run_at = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms <= 0; cyc <= 0; ref_at <= 0; pre_at <= 0; run_at <= 0;
        end else begin
            cyc <= cyc + 1;
            case (ms)
                0: if (cyc >= ref_at + REFI - 1) ms <= 2;
                2: if (pend == 0) ms <= 3;
                3: if (!asleep) begin
                       if (open_b) begin ms <= 4; pre_at <= cyc + 1; end
                       else begin ms <= 5; ref_at <= cyc + 1; end
                   end
                4: if (cyc >= pre_at + RP - 1) begin ms <= 5; ref_at <= cyc + 1; end
                5: begin ms <= 6; run_at <= cyc + 1; end
                6: if (cyc >= run_at + RFC - 1) ms <= sref ? 1 : 0;
                1: if (sdone) ms <= 2;
                default: ms <= 0;
            endcase
        end
    end

    function automatic string tag_of(input int s);
        case (s)
            0: return "R3";
            1: return "R9/R10";
            2: return "R4";
            3: return "R5/R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk({tag_of(ms), " state"}, int'(seq_state), ms);
            chk("R2 burst_ok", int'(burst_ok), int'(ms == 0));
            chk("R7 pre_all_stb", int'(pre_all_stb), int'(ms == 4 && cyc == pre_at));
            chk("R8 ref_stb", int'(ref_stb), int'(ms == 5));
            chk("R5 wake_req", int'(wake_req), int'(ms == 3 && asleep));
        end
    end

    task automatic wait_state(input int s);
        do @(negedge clk); while (int'(seq_state) != s);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual hung expected sequence completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 state", int'(seq_state), 0);
        chk("R1 burst_ok", int'(burst_ok), 1);
        chk("R1 strobes", int'({pre_all_stb, ref_stb, wake_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 state after release", int'(seq_state), 0);

        // Plain sequence: no pending, awake, banks closed
        wait_state(5);
        chk("R8 ref_stb in start", int'(ref_stb), 1);
        wait_state(0);
        chk("R2 burst_ok back in idle", int'(burst_ok), 1);

        // Drain with accesses in flight
        pend = 4'd3;
        wait_state(2);
        repeat (5) @(negedge clk);
        chk("R4 drain holds", int'(seq_state), 2);
        chk("R2 bursts blocked", int'(burst_ok), 0);
        pend = 4'd0;
        @(negedge clk);
        chk("R4 drain leaves", int'(seq_state), 3);
        wait_state(0);

        // Power-down exit and precharge
        asleep = 1'b1;
        open_b = 1'b1;
        wait_state(3);
        chk("R5 wake_req", int'(wake_req), 1);
        repeat (4) @(negedge clk);
        chk("R5 hold while asleep", int'(seq_state), 3);
        asleep = 1'b0;
        @(negedge clk);
        chk("R6 to precharge", int'(seq_state), 4);
        chk("R7 pre strobe", int'(pre_all_stb), 1);
        @(negedge clk);
        chk("R7 pre strobe single", int'(pre_all_stb), 0);
        open_b = 1'b0;
        wait_state(0);

        // Self-refresh re-entry
        sref = 1'b1;
        wait_state(6);
        wait_state(1);
        chk("R9 to self-refresh exit", int'(seq_state), 1);
        sref = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 hold", int'(seq_state), 1);
        sdone = 1'b1;
        @(negedge clk);
        chk("R10 to drain", int'(seq_state), 2);
        sdone = 1'b0;

        // Interval measured from refresh issue
        wait_state(5);
        begin
            int n = 0;
            do begin @(negedge clk); n++; end while (int'(seq_state) != 2);
            chk("R3 interval", n, REFI);
        end
        wait_state(0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule